// File: doc/BRIEF.md
# Delayed Configuration Commit Window

This block keeps a small bank of configuration registers. Each register has two copies. The programmed copy is what the host last wrote. The physical copy is what drives the datapath. A write can come from two places: a single-cycle serial write strobe carrying an index and data, or a per-register strobe that reports a change on a parallel control pin, which carries its own value. The programmed copy takes every write at once.

The physical copy follows a commit window. A write to a register whose window is closed goes straight to the physical copy. It also opens a window whose length, counted in cycle ticks, is a constant set separately for each register. A write that lands while the window is open only updates the programmed copy. It does not restart or lengthen the window. When the window runs out, the physical copy takes the newest programmed value.

A read port returns the programmed copy, so software can see a pending value before it takes effect. A busy output for each register shows that its window is open.

Top module: `cfg_commit_window`

## Requirements
- R1: After reset, every physical output and every programmed value equal that register's default, and every busy flag is 0. With the default parameters, the defaults are 0x10, 0x20 and 0x30 for registers 0, 1 and 2.
- R2: A serial write (`ser_we`=1) to a register whose busy flag is 0 updates that register's physical output at the next clock edge, and its busy flag reads 1 after that same edge.
- R3: The window counts only clock edges at which `tick`=1. Busy falls at the edge of the N-th tick after the opening write, where N is that register's delay. With the default parameters, N is 3, 5 and 2 for registers 0, 1 and 2. Cycles without a tick do not advance the window.
- R4: A write to a busy register updates the value returned on `rd_data` at the next edge, and it leaves the physical output unchanged while the window is open.
- R5: Writes during an open window neither restart nor extend it. Busy still falls at the N-th tick after the write that opened it.
- R6: At the edge where the window expires, the physical output takes the last value written, including a write in that same cycle.
- R7: A pulse on `pin_chg[i]` writes `pin_val` byte i (bits 8i+7:8i) into register i and follows the same window rules as a serial write.
- R8: When a serial write and a pin change hit the same register in the same cycle, the serial data is stored.
- R9: A serial write whose index is not below the register count has no effect on any physical output or busy flag.
- R10: `rd_data` returns the programmed value of register `rd_idx`, and it returns 0 for an index at or beyond the register count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Window time base, one count per high cycle |
| ser_we | input | 1 | Serial write strobe, one cycle |
| ser_idx | input | IDX_W | Serial write register index |
| ser_data | input | DATA_W | Serial write data |
| pin_chg | input | NUM_REGS | Per-register parallel pin change strobe |
| pin_val | input | NUM_REGS*DATA_W | Parallel pin values, one byte per register |
| rd_idx | input | IDX_W | Read register index |
| rd_data | output | DATA_W | Programmed value of the indexed register |
| phys_val | output | NUM_REGS*DATA_W | Physical values, one byte per register |
| busy | output | NUM_REGS | Commit window open, per register |

## Verification
The hardest case to reach from the ports is a write that lands in the exact cycle the window expires. Both the commit and the programmed-value update happen at one edge there. The stimulus counts ticks precisely: it opens a window and issues N-1 ticks. It then issues the write together with the final tick and checks that the physical output shows this newest value while busy drops. Repeated writes inside a window, placed on tick cycles, confirm that the fall of busy does not move.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [1:0] {
    WSRC_NONE   = 2'd0,
    WSRC_SERIAL = 2'd1,
    WSRC_PIN    = 2'd2
  } wsrc_e;

  function automatic logic idx_hit(input int unsigned idx, input int unsigned slot);
    return idx == slot;
  endfunction

endpackage

// File: rtl/cfgw_wr_route.sv
module cfgw_wr_route
  import cfgw_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_we,
  input  logic [IDX_W-1:0]           ser_idx,
  input  logic [DATA_W-1:0]          ser_data,
  input  logic [NUM_REGS-1:0]        pin_chg,
  input  logic [NUM_REGS*DATA_W-1:0] pin_val,
  output logic [NUM_REGS-1:0]        slot_we,
  output logic [NUM_REGS*DATA_W-1:0] slot_data
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_route
    wsrc_e src;

    always_comb begin
      if (ser_we && idx_hit(int'(ser_idx), i)) begin
        src = WSRC_SERIAL;
      end else if (pin_chg[i]) begin
        src = WSRC_PIN;
      end else begin
        src = WSRC_NONE;
      end
    end

    always_comb begin
      slot_we[i] = (src != WSRC_NONE);
      unique case (src)
        WSRC_SERIAL: slot_data[i*DATA_W +: DATA_W] = ser_data;
        WSRC_PIN:    slot_data[i*DATA_W +: DATA_W] = pin_val[i*DATA_W +: DATA_W];
        default:     slot_data[i*DATA_W +: DATA_W] = '0;
      endcase
    end

    // R8: serial data wins over a simultaneous pin change
    assert_serial_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_we && (int'(ser_idx) == i) && pin_chg[i]) |->
        (slot_we[i] && slot_data[i*DATA_W +: DATA_W] == ser_data));
  end

endmodule

// File: rtl/cfgw_slot.sv
module cfgw_slot #(
  parameter int               DATA_W  = 8,
  parameter int               CNT_W   = 8,
  parameter logic [CNT_W-1:0] DELAY   = 3,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] prog_q,
  output logic [DATA_W-1:0] phys_q,
  output logic              busy
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] prog_d, phys_d;
  logic              win_open, win_last, prog_en, phys_en, cnt_en;

  assign win_open = (cnt_q != '0);
  assign win_last = win_open && tick && (cnt_q == ONE);
  assign busy     = win_open;

  always_comb begin
    prog_d  = we ? wdata : prog_q;
    prog_en = we;
  end

  always_comb begin
    phys_d  = phys_q;
    cnt_d   = cnt_q;
    phys_en = 1'b0;
    cnt_en  = 1'b0;
    if (!win_open) begin
      if (we) begin
        phys_d  = wdata;
        phys_en = 1'b1;
        cnt_d   = DELAY;
        cnt_en  = 1'b1;
      end
    end else if (tick) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
      if (win_last) begin
        phys_d  = prog_d;
        phys_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= RST_VAL;
    end else if (prog_en) begin
      prog_q <= prog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_q <= RST_VAL;
    end else if (phys_en) begin
      phys_q <= phys_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: a write with the window closed reaches the physical value at once
  assert_direct_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !busy) |=> (phys_q == $past(wdata)));

  // R4: physical value frozen while the window stays open
  assert_phys_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(tick && cnt_q == ONE)) |=> $stable(phys_q));

  // R5: writes never reload a running window; it only moves on ticks
  assert_no_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(cnt_q));

  assert_counts_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick) |=> (cnt_q == $past(cnt_q) - ONE));

  // R6: expiry commits the newest programmed value
  assert_commit_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && cnt_q == ONE) |=> (!busy && phys_q == prog_q));

endmodule

// File: rtl/cfgw_read_sel.sv
module cfgw_read_sel #(
  parameter int NUM_REGS = 3,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 2
) (
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_REGS*DATA_W-1:0] prog_flat,
  output logic [DATA_W-1:0]          rd_data
);

  logic [NUM_REGS-1:0][DATA_W-1:0] masked;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_mask
    assign masked[i] = (int'(rd_idx) == i) ? prog_flat[i*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      rd_data = rd_data | masked[i];
    end
  end

endmodule

// File: rtl/cfg_commit_window.sv
module cfg_commit_window #(
  parameter int NUM_REGS = 3,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int IDX_W    = 2,
  parameter logic [NUM_REGS*CNT_W-1:0]  DELAYS   = {8'd2, 8'd5, 8'd3},
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VALS = {8'h30, 8'h20, 8'h10}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       ser_we,
  input  logic [IDX_W-1:0]           ser_idx,
  input  logic [DATA_W-1:0]          ser_data,
  input  logic [NUM_REGS-1:0]        pin_chg,
  input  logic [NUM_REGS*DATA_W-1:0] pin_val,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] phys_val,
  output logic [NUM_REGS-1:0]        busy
);

  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic [NUM_REGS-1:0] slot_we;
  logic [FLAT_W-1:0]   slot_data;
  logic [FLAT_W-1:0]   prog_flat;

  cfgw_wr_route #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_we   (ser_we),
    .ser_idx  (ser_idx),
    .ser_data (ser_data),
    .pin_chg  (pin_chg),
    .pin_val  (pin_val),
    .slot_we  (slot_we),
    .slot_data(slot_data)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    cfgw_slot #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .DELAY  (DELAYS[i*CNT_W +: CNT_W]),
      .RST_VAL(RST_VALS[i*DATA_W +: DATA_W])
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .we    (slot_we[i]),
      .wdata (slot_data[i*DATA_W +: DATA_W]),
      .prog_q(prog_flat[i*DATA_W +: DATA_W]),
      .phys_q(phys_val[i*DATA_W +: DATA_W]),
      .busy  (busy[i])
    );
  end

  cfgw_read_sel #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_read (
    .rd_idx   (rd_idx),
    .prog_flat(prog_flat),
    .rd_data  (rd_data)
  );

  // R9: an out-of-range serial index starts no window anywhere
  assert_bad_idx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_we && int'(ser_idx) >= NUM_REGS && pin_chg == '0) |=>
      $stable(phys_val));

endmodule

// File: tb/tb_cfg_commit_window.sv
module tb_cfg_commit_window;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, tick, ser_we;
  logic [1:0]  ser_idx, rd_idx;
  logic [7:0]  ser_data, rd_data;
  logic [2:0]  pin_chg, busy;
  logic [23:0] pin_val, phys_val;

  cfg_commit_window dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ser_we(ser_we), .ser_idx(ser_idx),
    .ser_data(ser_data), .pin_chg(pin_chg), .pin_val(pin_val), .rd_idx(rd_idx),
    .rd_data(rd_data), .phys_val(phys_val), .busy(busy)
  );

  typedef struct {
    int         sel;   // 0 physical, 1 busy, 2 read data
    int         idx;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_out(input int sel, input int idx, input logic [7:0] e, input string r);
    item_t it;
    it.sel = sel; it.idx = idx; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic drive(input bit tk, input bit swe, input logic [1:0] sidx,
                       input logic [7:0] sd, input logic [2:0] pchg,
                       input logic [23:0] pv, input logic [1:0] ridx);
    @(negedge clk);
    tick = tk; ser_we = swe; ser_idx = sidx; ser_data = sd;
    pin_chg = pchg; pin_val = pv; rd_idx = ridx;
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #2;
  endtask

  // monitor: pops every queued expectation shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.sel)
          0:       act = phys_val[it.idx*8 +: 8];
          1:       act = {7'd0, busy[it.idx]};
          default: act = rd_data;
        endcase
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s sel=%0d idx=%0d actual=%h expected=%h", it.req, it.sel, it.idx, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; ser_we = 0; ser_idx = 0; ser_data = 0;
    pin_chg = 0; pin_val = 0; rd_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    drive(0, 0, 0, 0, 0, 0, 0);
    expect_out(0, 0, 8'h10, "R1"); expect_out(0, 1, 8'h20, "R1");
    expect_out(0, 2, 8'h30, "R1"); expect_out(2, 0, 8'h10, "R1");
    for (int i = 0; i < 3; i++) expect_out(1, i, 0, "R1");
    edge_wait();

    // R2 direct apply, R3 tick-only counting (reg0 delay 3)
    drive(0, 1, 0, 8'hA5, 0, 0, 0);
    expect_out(0, 0, 8'hA5, "R2"); expect_out(1, 0, 1, "R2"); edge_wait();
    for (int i = 0; i < 2; i++) begin
      drive(0, 0, 0, 0, 0, 0, 0); expect_out(1, 0, 1, "R3"); edge_wait();
    end
    for (int i = 0; i < 2; i++) begin
      drive(1, 0, 0, 0, 0, 0, 0); expect_out(1, 0, 1, "R3"); edge_wait();
    end
    drive(1, 0, 0, 0, 0, 0, 0);
    expect_out(1, 0, 0, "R3"); expect_out(0, 0, 8'hA5, "R3"); edge_wait();

    // R4 R5 R6 on reg1 (delay 5)
    drive(0, 1, 1, 8'h11, 0, 0, 1);
    expect_out(0, 1, 8'h11, "R2"); expect_out(1, 1, 1, "R2"); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 1); expect_out(1, 1, 1, "R5"); edge_wait();
    drive(1, 1, 1, 8'h22, 0, 0, 1);
    expect_out(0, 1, 8'h11, "R4"); expect_out(2, 1, 8'h22, "R4"); edge_wait();
    drive(1, 1, 1, 8'h33, 0, 0, 1);
    expect_out(0, 1, 8'h11, "R4"); expect_out(2, 1, 8'h33, "R4"); expect_out(1, 1, 1, "R5"); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 1); expect_out(1, 1, 1, "R5"); expect_out(0, 1, 8'h11, "R4"); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 1);
    expect_out(1, 1, 0, "R5"); expect_out(0, 1, 8'h33, "R6"); edge_wait();

    // R7 parallel pin change on reg2 (delay 2)
    drive(0, 0, 0, 0, 3'b100, 24'h5A0000, 2);
    expect_out(0, 2, 8'h5A, "R7"); expect_out(1, 2, 1, "R7"); expect_out(2, 2, 8'h5A, "R7"); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 2); expect_out(1, 2, 1, "R7"); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 2); expect_out(1, 2, 0, "R7"); edge_wait();

    // R8 serial beats pin in the same cycle
    drive(0, 1, 2, 8'h77, 3'b100, 24'h660000, 2);
    expect_out(0, 2, 8'h77, "R8"); expect_out(2, 2, 8'h77, "R8"); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 2); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 2); expect_out(1, 2, 0, "R8"); edge_wait();

    // R9 out-of-range serial index
    drive(0, 1, 3, 8'hFF, 0, 0, 0);
    expect_out(0, 0, 8'hA5, "R9"); expect_out(0, 1, 8'h33, "R9"); expect_out(0, 2, 8'h77, "R9");
    for (int i = 0; i < 3; i++) expect_out(1, i, 0, "R9");
    edge_wait();

    // R10 read port
    drive(0, 0, 0, 0, 0, 0, 3); expect_out(2, 0, 8'h00, "R10"); edge_wait();
    drive(0, 0, 0, 0, 0, 0, 1); expect_out(2, 0, 8'h33, "R10"); edge_wait();

    // R6 write in the expiry cycle, then R2 reopen
    drive(0, 1, 0, 8'h01, 0, 0, 0); expect_out(0, 0, 8'h01, "R2"); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 0); edge_wait();
    drive(1, 0, 0, 0, 0, 0, 0); expect_out(1, 0, 1, "R3"); edge_wait();
    drive(1, 1, 0, 8'h02, 0, 0, 0);
    expect_out(0, 0, 8'h02, "R6"); expect_out(1, 0, 0, "R6"); edge_wait();
    drive(0, 1, 0, 8'h03, 0, 0, 0);
    expect_out(0, 0, 8'h03, "R2"); expect_out(1, 0, 1, "R2"); edge_wait();

    drive(0, 0, 0, 0, 0, 0, 0);
    edge_wait();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule